// File: doc/BRIEF.md
# Single-Wire Pulse-Count LED Controller

This block turns a single control wire into LED drive settings. A host programs it by sending a burst of pulses. The number of rising edges in the burst is the command. The block brings the wire into the system clock domain and filters it. It then counts the rising edges of a programming frame. It moves that count into a five-bit setting register only after the wire has stayed high for a programmable hold time. Counts 1 to 4 select an indicator mode in which only the second LED runs, at one of four current levels. Counts 5 to 20 select normal backlight operation, in which both LEDs run at one of sixteen current steps and the converter is enabled.

The wire also acts as the power switch. While the filtered wire is low, every output is forced off. A short low, such as the gap between pulses, keeps the stored setting. A low that lasts longer than the off-time parameter clears the setting to zero. A high pause shorter than the hold time does not end the frame, so a host can break a burst into parts. All timing thresholds are parameters counted in clock cycles.

Top module: `pulse_led_ctrl`

## Requirements
- R1: A falling edge on `ctl_in` turns `conv_en`, `led1_on`, `led2_on`, `icon_mode`, `icon_level` and `led_step` all to zero exactly 2 + FILT_CYC clock edges after the change, which is 6 edges at default parameters. The outputs stay zero while the filtered line is low.
- R2: A level change on `ctl_in` that lasts fewer than FILT_CYC cycles is ignored. It neither counts as a pulse nor blanks the outputs.
- R3: A stored count n of 1 to 4 gives `icon_mode`=1, `icon_level`=n-1, `led2_on`=1, `led1_on`=0 and `conv_en`=0.
- R4: A stored count n of 5 to 20 gives `icon_mode`=0, `led_step`=n-5, `conv_en`=1, `led1_on`=1 and `led2_on`=1.
- R5: Rising edges after the twentieth in one frame do not change the count. A burst of 25 pulses gives `led_step`=15.
- R6: The count is stored only when the filtered line has been high for STORE_CYC consecutive cycles. Until then the outputs show the previous setting. A high phase of STORE_CYC-1 cycles stores nothing.
- R7: A high pause shorter than STORE_CYC cycles does not end the frame. Pulses sent after the pause add to the count already taken.
- R8: After a store, the next rising edge starts a new frame with a count of 1.
- R9: A low phase longer than OFF_CYC cycles clears the stored setting to zero. When the line returns high, all outputs stay zero until a new store.
- R10: After reset the stored setting is zero and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_in | input | 1 | Asynchronous single-wire control line |
| conv_en | output | 1 | Converter enable, set in normal mode |
| led1_on | output | 1 | First LED current sink enable |
| led2_on | output | 1 | Second LED current sink enable |
| icon_mode | output | 1 | Indicator mode active |
| icon_level | output | 2 | Indicator current level, 0 to 3 |
| led_step | output | 4 | Backlight current step, 0 to 15 |

## Verification
Two pieces of logic can act on the same cycle: the hold timer can expire, and the line can drop and blank the outputs. This happens at the end of a high phase whose length is right at the store threshold. The bench provokes it with one high phase of STORE_CYC-1 cycles and another of exactly STORE_CYC cycles, each followed by a low and one more pulse. It judges the result by the final setting. A frame that continued gives step 5, and a frame that was stored and then restarted gives indicator level 0. Blanking at the instant of the drop is checked separately, on the edge before and the edge after the expected switch-off.

// File: rtl/pulse_led_pkg.sv
package pulse_led_pkg;

    localparam int ICON_LEVELS = 4;
    localparam int BL_STEPS    = 16;
    localparam int MAX_COUNT   = ICON_LEVELS + BL_STEPS;
    localparam int CNT_W       = $clog2(MAX_COUNT + 1);
    localparam int LVL_W       = $clog2(ICON_LEVELS);
    localparam int STEP_W      = $clog2(BL_STEPS);

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic              conv_en;
        logic              led1_on;
        logic              led2_on;
        logic              icon_mode;
        logic [LVL_W-1:0]  icon_level;
        logic [STEP_W-1:0] led_step;
    } drive_t;

    // Map a stored pulse count onto the drive settings.
    function automatic drive_t decode_count(input count_t n);
        drive_t d;
        d = '0;
        if (n == '0) begin
            d = '0;
        end else if (n <= count_t'(ICON_LEVELS)) begin
            d.icon_mode  = 1'b1;
            d.led2_on    = 1'b1;
            d.icon_level = LVL_W'(n - count_t'(1));
        end else begin
            d.conv_en  = 1'b1;
            d.led1_on  = 1'b1;
            d.led2_on  = 1'b1;
            d.led_step = STEP_W'(n - count_t'(ICON_LEVELS + 1));
        end
        return d;
    endfunction

endpackage

// File: rtl/pl_line_filter.sv
module pl_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic line_f
);
    localparam int FW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [FW-1:0]          run;

    // Synchroniser chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Accept a new level only after FILT_CYC consecutive disagreeing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            line_f <= 1'b0;
            run    <= '0;
        end else if (chain[SYNC_STAGES-1] == line_f) begin
            run <= '0;
        end else if (run == FW'(FILT_CYC - 1)) begin
            line_f <= chain[SYNC_STAGES-1];
            run    <= '0;
        end else begin
            run <= run + FW'(1);
        end
    end
endmodule

// File: rtl/pl_frame_ctrl.sv
module pl_frame_ctrl
    import pulse_led_pkg::*;
#(
    parameter int STORE_CYC = 64,
    parameter int OFF_CYC   = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   line_f,
    output count_t reg_q
);
    localparam int HW = $clog2(STORE_CYC + 1);
    localparam int LW = $clog2(OFF_CYC + 1);

    logic          line_prev;
    logic          frame_open;
    count_t        pulse_cnt;
    logic [HW-1:0] high_run;
    logic [LW-1:0] low_run;
    logic          rise, commit, expire;

    assign rise   = line_f & ~line_prev;
    assign commit = line_f & frame_open & (high_run == HW'(STORE_CYC - 1));
    assign expire = ~line_f & (low_run == LW'(OFF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_prev  <= 1'b0;
            frame_open <= 1'b0;
            pulse_cnt  <= '0;
            high_run   <= '0;
            low_run    <= '0;
            reg_q      <= '0;
        end else begin
            line_prev <= line_f;
            // Phase timers.
            if (line_f) begin
                low_run <= '0;
                if (high_run != HW'(STORE_CYC)) high_run <= high_run + HW'(1);
            end else begin
                high_run <= '0;
                if (low_run != LW'(OFF_CYC)) low_run <= low_run + LW'(1);
            end
            // Pulse counting: the first rise of a frame restarts at one.
            if (rise) begin
                if (!frame_open) begin
                    pulse_cnt  <= count_t'(1);
                    frame_open <= 1'b1;
                end else if (pulse_cnt != count_t'(MAX_COUNT)) begin
                    pulse_cnt <= pulse_cnt + count_t'(1);
                end
            end
            // Store after the high hold.
            if (commit) begin
                reg_q      <= pulse_cnt;
                frame_open <= 1'b0;
            end
            // Long low: full shutdown.
            if (expire) begin
                reg_q      <= '0;
                pulse_cnt  <= '0;
                frame_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pl_drive_decode.sv
module pl_drive_decode
    import pulse_led_pkg::*;
(
    input  logic   line_f,
    input  count_t reg_q,
    output drive_t drive
);
    always_comb begin
        if (line_f) drive = decode_count(reg_q);
        else        drive = '0;
    end
endmodule

// File: rtl/pulse_led_ctrl.sv
module pulse_led_ctrl
    import pulse_led_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4,
    parameter int STORE_CYC   = 64,
    parameter int OFF_CYC     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_in,
    output logic              conv_en,
    output logic              led1_on,
    output logic              led2_on,
    output logic              icon_mode,
    output logic [LVL_W-1:0]  icon_level,
    output logic [STEP_W-1:0] led_step
);
    logic   line_f;
    count_t reg_q;
    drive_t drive;

    pl_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filter (
        .clk(clk), .rst(rst), .raw_in(ctl_in), .line_f(line_f)
    );

    pl_frame_ctrl #(.STORE_CYC(STORE_CYC), .OFF_CYC(OFF_CYC)) u_frame (
        .clk(clk), .rst(rst), .line_f(line_f), .reg_q(reg_q)
    );

    pl_drive_decode u_decode (
        .line_f(line_f), .reg_q(reg_q), .drive(drive)
    );

    assign conv_en    = drive.conv_en;
    assign led1_on    = drive.led1_on;
    assign led2_on    = drive.led2_on;
    assign icon_mode  = drive.icon_mode;
    assign icon_level = drive.icon_level;
    assign led_step   = drive.led_step;
endmodule

// File: rtl/pulse_led_chk.sv
module pulse_led_chk
    import pulse_led_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   line_f,
    input count_t reg_q,
    input logic   conv_en,
    input logic   led1_on,
    input logic   led2_on,
    input logic   icon_mode
);
    // R1: a low filtered line leaves every drive off
    p_dark_when_low_r1: assert property (@(posedge clk) disable iff (rst)
        !line_f |-> (!conv_en && !led1_on && !led2_on && !icon_mode));

    // R3: indicator mode never runs the converter or the first LED
    p_icon_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        icon_mode |-> (!conv_en && !led1_on && led2_on));

    // R4: converter on implies both LEDs on in normal mode
    p_normal_both_r4: assert property (@(posedge clk) disable iff (rst)
        conv_en |-> (led1_on && led2_on && !icon_mode));

    // R5: the stored count never passes the saturation value
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        reg_q <= count_t'(MAX_COUNT));

    // R6: a nonzero value is stored only while the line is high
    p_store_when_high_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_q != $past(reg_q) && reg_q != '0) |-> $past(line_f));

    // R9: the setting is cleared only during a low phase
    p_clear_when_low_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_q == '0 && $past(reg_q) != '0) |-> !$past(line_f));
endmodule

bind pulse_led_ctrl pulse_led_chk u_chk (
    .clk(clk), .rst(rst), .line_f(line_f), .reg_q(reg_q),
    .conv_en(conv_en), .led1_on(led1_on), .led2_on(led2_on),
    .icon_mode(icon_mode)
);

// File: tb/test_pulse_led_ctrl.sv
`timescale 1ns/1ps
module test_pulse_led_ctrl;
    localparam int FILT  = 4;
    localparam int STORE = 64;
    localparam int OFF   = 32;
    localparam int HI    = 10;
    localparam int LO    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl = 1'b0;
    logic conv_en, led1_on, led2_on, icon_mode;
    logic [1:0] icon_level;
    logic [3:0] led_step;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    always #4 clk = ~clk;

    pulse_led_ctrl #(.FILT_CYC(FILT), .STORE_CYC(STORE), .OFF_CYC(OFF)) i_pulse_led_ctrl (
        .clk(clk), .rst(rst), .ctl_in(ctl), .conv_en(conv_en), .led1_on(led1_on),
        .led2_on(led2_on), .icon_mode(icon_mode), .icon_level(icon_level), .led_step(led_step)
    );

    // Expected drive vector {conv, led1, led2, icon, level[1:0], step[3:0]} from a count.
    function automatic logic [9:0] exp_of(int n);
        logic [9:0] v;
        v = '0;
        if (n >= 1 && n <= 4) begin
            v[6]   = 1'b1;
            v[7]   = 1'b1;
            v[5:4] = 2'(n - 1);
        end else if (n >= 5) begin
            v[9] = 1'b1;
            v[8] = 1'b1;
            v[7] = 1'b1;
            v[3:0] = 4'(n - 5);
        end
        return v;
    endfunction

    function automatic logic [9:0] got();
        return {conv_en, led1_on, led2_on, icon_mode, icon_level, led_step};
    endfunction

    // Behavioural reference: two-sample input delay, run-length filter,
    // phase lengths and a frame tally kept as plain integers.
    int q_raw[$];
    bit m_line, m_prev, m_open, d_in, f_old;
    int mis_run, hi_run, lo_run, m_cnt, m_reg;

    always @(posedge clk) begin
        if (rst) begin
            q_raw = {0, 0};
            m_line = 0; m_prev = 0; m_open = 0;
            mis_run = 0; hi_run = 0; lo_run = 0; m_cnt = 0; m_reg = 0;
        end else begin
            d_in = q_raw[0][0];
            void'(q_raw.pop_front());
            q_raw.push_back(int'(ctl));
            f_old = m_line;
            if (f_old) begin
                lo_run = 0;
                if (hi_run < STORE) hi_run++;
            end else begin
                hi_run = 0;
                if (lo_run < OFF) lo_run++;
            end
            if (f_old && !m_prev) begin
                if (!m_open) begin m_cnt = 1; m_open = 1; end
                else if (m_cnt < 20) m_cnt++;
            end
            if (f_old && m_open && hi_run == STORE) begin m_reg = m_cnt; m_open = 0; end
            if (!f_old && lo_run == OFF) begin m_reg = 0; m_cnt = 0; m_open = 0; end
            m_prev = f_old;
            if (d_in != m_line) begin
                mis_run++;
                if (mis_run == FILT) begin m_line = d_in; mis_run = 0; end
            end else begin
                mis_run = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [9:0] e;
            e = m_line ? exp_of(m_reg) : 10'd0;
            checks++;
            if (got() !== e) begin
                errors++;
                $display("FAIL %s model compare at %0t: actual %b expected %b", cur_req, $time, got(), e);
            end
        end
    end

    task automatic check_n(string req, int n);
        checks++;
        if (got() !== exp_of(n)) begin
            errors++;
            $display("FAIL %s directed: actual %b expected %b", req, got(), exp_of(n));
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            ctl = 1'b0; cyc(LO);
            ctl = 1'b1; cyc(HI);
        end
    endtask

    task automatic hold();
        ctl = 1'b1; cyc(STORE + 12);
    endtask

    task automatic shutdown();
        ctl = 1'b0; cyc(OFF + 20);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(3);
        cur_req = "R10"; check_n("R10", 0);                  // reset state

        cur_req = "R3";  pulses(3); hold(); check_n("R3", 3);  // level 2
        pulses(4);
        cur_req = "R6";  check_n("R6", 3);                     // old value during frame
        hold(); check_n("R3", 4);                              // level 3

        cur_req = "R4";  pulses(5); hold(); check_n("R4", 5);
        pulses(12); hold(); check_n("R4", 12);

        cur_req = "R5";  pulses(25); hold(); check_n("R5", 20);

        cur_req = "R7";  pulses(3); ctl = 1'b1; cyc(40);
        pulses(3); hold(); check_n("R7", 6);

        cur_req = "R6";  pulses(8);
        ctl = 1'b0; cyc(LO); ctl = 1'b1; cyc(STORE - 1);       // one short of store
        pulses(1); hold(); check_n("R6", 10);
        pulses(8);
        ctl = 1'b0; cyc(LO); ctl = 1'b1; cyc(STORE);           // exactly store
        cur_req = "R8";  pulses(1); hold(); check_n("R8", 1);

        cur_req = "R4";  pulses(12); hold(); check_n("R4", 12);
        cur_req = "R2";  ctl = 1'b0; cyc(FILT - 1); ctl = 1'b1; cyc(20);
        check_n("R2", 12);                                     // low glitch ignored
        cur_req = "R1";  ctl = 1'b0; cyc(5); check_n("R1", 12);
        cyc(1); check_n("R1", 0);
        cyc(6); ctl = 1'b1; cyc(2 + FILT + 2);
        cur_req = "R6";  check_n("R6", 12);                    // setting kept over short low
        cur_req = "R8";  hold(); check_n("R8", 1);

        cur_req = "R9";  shutdown(); ctl = 1'b1; cyc(20);
        check_n("R9", 0);
        cyc(STORE); check_n("R9", 1);

        cur_req = "R2";  shutdown();
        ctl = 1'b1; cyc(FILT - 1); ctl = 1'b0; cyc(20);        // high glitch
        check_n("R2", 0);
        pulses(2); hold(); check_n("R2", 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule